// File: doc/BRIEF.md
# Pixel Word Serializer with Parity

This block turns one 27-bit parallel video word per pixel period (24 colour bits and 3 control bits) into a 30-bit serial frame. The frame is the 27 data bits, an odd parity bit and two reserved zero bits. It is sent least significant bit first, either on one serial lane at 30 bit-clock cycles per pixel or split across two lanes at 15 cycles per pixel. Everything runs in the single bit-rate clock domain. The incoming pixel clock is treated as a data signal: it is sampled through a short synchroniser, and its rising or falling transition, chosen by a polarity input, marks the moment the word is captured.

Beside the data lanes the block drives a regenerated pixel clock. This clock is built from a phase counter in the bit clock and realigned on every capture. A power controller tracks three states. Shutdown is forced by an active-low input and clears all state. Standby is entered automatically when capture edges stop arriving. Active is resumed on the first capture edge after standby. In every state other than active, with a frame loaded, the serial and clock outputs are held low.

Top module: `pxser_top`

## Requirements
- R1: In single-lane mode, lane0 sends frame bit j in the j-th bit-clock cycle after a capture, for j = 0..29. Frame bits 0..26 are the word LSB first, bit 27 is the parity bit and bits 28..29 are 0. The parity bit makes the count of ones over the 27 data bits plus parity odd.
- R2: In single-lane mode, lane1 stays at 0 at all times.
- R3: In dual-lane mode, lane0 carries frame bits 0..14 and lane1 carries frame bits 15..29, one bit of each per bit-clock cycle, over 15 cycles.
- R4: cap_fall = 0 captures on a 0-to-1 transition of pix_clk and cap_fall = 1 on a 1-to-0 transition. Frame bit 0 appears on lane0 after the third rising bit-clock edge following the pix_clk transition, and the word is taken at that edge.
- R5: While a frame is loaded, clk_copy repeats with period P (30 single, 15 dual). It is high for the first 15 (single) or 8 (dual) cycles of each period, with phase 0 aligned to frame bit 0.
- R6: After 64 bit-clock cycles without a capture edge, pwr_state goes to standby (2'b01), and lane0, lane1 and clk_copy are 0 while in standby.
- R7: In standby, the first capture edge moves pwr_state to active (2'b10) but sends no frame. The outputs stay 0 until the word of the next capture edge is loaded.
- R8: While shutdown_n is 0, pwr_state reads shutdown (2'b00). The cycle after shutdown_n falls, all outputs are 0 and any frame is dropped. After release the block starts in standby.
- R9: A gap between capture edges shorter than 64 bit-clock cycles keeps pwr_state at active.
- R10: pwr_state never takes the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit-rate clock |
| shutdown_n | input | 1 | Active-low shutdown, also the synchronous reset |
| pix_clk | input | 1 | Pixel clock, sampled as data |
| cap_fall | input | 1 | 0: capture on rising pix_clk, 1: on falling |
| dual_lane | input | 1 | 0: one lane, 30 bits per pixel; 1: two lanes, 15 bits each |
| pix_word | input | 27 | Parallel word: colour bits and control bits |
| lane0 | output | 1 | Serial lane 0 |
| lane1 | output | 1 | Serial lane 1 (dual-lane mode only) |
| clk_copy | output | 1 | Regenerated pixel clock |
| pwr_state | output | 2 | 00 shutdown, 01 standby, 10 active |

## Verification
The assertions assume the following about the inputs:
- pix_clk changes slowly against clk_bit.
- pix_word is steady from the capture transition until the load three cycles later.
- Capture edges arrive exactly one frame period apart while active.
- dual_lane and cap_fall change only in standby.

The stimulus changes the word only together with the capture transition, at least 15 cycles before the next load. It drives each pixel period at exactly 30 or 15 bit cycles. Before any mode or polarity change it idles for 100 cycles to reach standby, so a mode switch never lands inside a frame.

// File: rtl/pxser_pkg.sv
`timescale 1ns/1ps
// Shared types for the pixel word serializer.
package pxser_pkg;
    // Power state codes, also driven on the pwr_state port.
    typedef enum logic [1:0] {
        PWR_OFF  = 2'b00,
        PWR_STBY = 2'b01,
        PWR_RUN  = 2'b10
    } pwr_e;
endpackage

// File: rtl/pxser_edge.sv
`timescale 1ns/1ps
// Pixel-clock sampler: brings pix_clk through SYNC_STAGES flops into the
// bit-clock domain and flags the selected transition for one cycle.
// Assumes pix_clk is much slower than clk_bit.
module pxser_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_bit,
    input  logic rst_n,
    input  logic pix_clk,
    input  logic cap_fall,
    output logic cap_edge
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                // First stage samples the raw pixel clock.
                always_ff @(posedge clk_bit) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pix_clk;
                end
            end else begin : g_next
                // Later stages extend the chain.
                always_ff @(posedge clk_bit) begin
                    if (!rst_n) sync_q[s] <= 1'b0;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    // Keeps the previous synchronised level for transition detection.
    always_ff @(posedge clk_bit) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Selects the rising or falling transition as the capture event.
    always_comb begin
        if (cap_fall) cap_edge = prev_q & ~sync_q[SYNC_STAGES-1];
        else          cap_edge = sync_q[SYNC_STAGES-1] & ~prev_q;
    end
endmodule

// File: rtl/pxser_power.sv
`timescale 1ns/1ps
// Power controller: standby/active state plus an idle counter that drops
// to standby after IDLE_LIMIT cycles with no capture edge. Shutdown is the
// synchronous reset. Assumes IDLE_LIMIT >= 2.
module pxser_power import pxser_pkg::*; #(
    parameter int IDLE_LIMIT = 64
) (
    input  logic clk_bit,
    input  logic rst_n,
    input  logic cap_edge,
    output pwr_e state_q,
    output logic run_next,
    output logic cap_load
);
    localparam int            CW   = $clog2(IDLE_LIMIT);
    localparam logic [CW-1:0] LAST = CW'(IDLE_LIMIT - 1);

    logic [CW-1:0] idle_q, idle_d;
    pwr_e          state_d;

    // Next-state and idle-count logic.
    always_comb begin
        state_d = state_q;
        idle_d  = idle_q;
        case (state_q)
            PWR_STBY: begin
                if (cap_edge) begin
                    state_d = PWR_RUN;
                    idle_d  = '0;
                end
            end
            PWR_RUN: begin
                if (cap_edge) begin
                    idle_d = '0;
                end else if (idle_q == LAST) begin
                    state_d = PWR_STBY;
                    idle_d  = '0;
                end else begin
                    idle_d = idle_q + 1'b1;
                end
            end
            default: begin
                state_d = PWR_STBY;
                idle_d  = '0;
            end
        endcase
    end

    // State and counter registers; reset lands in standby.
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            state_q <= PWR_STBY;
            idle_q  <= '0;
        end else begin
            state_q <= state_d;
            idle_q  <= idle_d;
        end
    end

    assign run_next = (state_d == PWR_RUN);
    assign cap_load = cap_edge && (state_q == PWR_RUN);
endmodule

// File: rtl/pxser_shift.sv
`timescale 1ns/1ps
// Frame builder and shifter: appends odd parity and reserved zeros to the
// word, loads the frame on cap_load and shifts it right one bit per cycle.
// A single register serves both lane modes: lane1 taps the upper half.
// Assumes the frame width is even.
module pxser_shift #(
    parameter int DATA_W = 27,
    parameter int RSV_W  = 2
) (
    input  logic              clk_bit,
    input  logic              rst_n,
    input  logic              run_next,
    input  logic              cap_load,
    input  logic              dual_lane,
    input  logic [DATA_W-1:0] pix_word,
    output logic              lane0,
    output logic              lane1,
    output logic              frame_valid
);
    localparam int FRAME_W = DATA_W + 1 + RSV_W;
    localparam int HALF    = FRAME_W / 2;

    logic [FRAME_W-1:0] sh_q, frame;

    // Frame layout: data low, parity above it, reserved zeros on top.
    assign frame = {{RSV_W{1'b0}}, ~^pix_word, pix_word};

    // Loads, shifts or clears the frame register.
    always_ff @(posedge clk_bit) begin
        if (!rst_n || !run_next) begin
            sh_q        <= '0;
            frame_valid <= 1'b0;
        end else if (cap_load) begin
            sh_q        <= frame;
            frame_valid <= 1'b1;
        end else begin
            sh_q <= {1'b0, sh_q[FRAME_W-1:1]};
        end
    end

    assign lane0 = sh_q[0];
    assign lane1 = dual_lane & sh_q[HALF];
endmodule

// File: rtl/pxser_clkcopy.sv
`timescale 1ns/1ps
// Regenerated pixel clock: a phase counter with the frame period, restarted
// on each load, high for the first half (rounded up) of the period.
module pxser_clkcopy #(
    parameter int FRAME_W = 30
) (
    input  logic clk_bit,
    input  logic rst_n,
    input  logic cap_load,
    input  logic dual_lane,
    input  logic frame_valid,
    output logic clk_copy
);
    localparam int            HALF      = FRAME_W / 2;
    localparam int            PW        = $clog2(FRAME_W);
    localparam logic [PW-1:0] FULL_LAST = PW'(FRAME_W - 1);
    localparam logic [PW-1:0] HALF_LAST = PW'(HALF - 1);
    localparam logic [PW-1:0] FULL_HI   = PW'((FRAME_W + 1) / 2);
    localparam logic [PW-1:0] HALF_HI   = PW'((HALF + 1) / 2);

    logic [PW-1:0] ph_q;
    logic [PW-1:0] last, hi;

    // Period and high time for the current lane mode.
    assign last = dual_lane ? HALF_LAST : FULL_LAST;
    assign hi   = dual_lane ? HALF_HI   : FULL_HI;

    // Phase counter, realigned to zero on every load.
    always_ff @(posedge clk_bit) begin
        if (!rst_n || cap_load) ph_q <= '0;
        else if (ph_q == last)  ph_q <= '0;
        else                    ph_q <= ph_q + 1'b1;
    end

    assign clk_copy = frame_valid && (ph_q < hi);
endmodule

// File: rtl/pxser_top.sv
`timescale 1ns/1ps
// Pixel word serializer top: sampler, power controller, frame shifter and
// clock regenerator. shutdown_n acts as the synchronous active-low reset.
// Assumes one capture edge per frame period while active.
module pxser_top import pxser_pkg::*; #(
    parameter int DATA_W      = 27,
    parameter int RSV_W       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_LIMIT  = 64
) (
    input  logic              clk_bit,
    input  logic              shutdown_n,
    input  logic              pix_clk,
    input  logic              cap_fall,
    input  logic              dual_lane,
    input  logic [DATA_W-1:0] pix_word,
    output logic              lane0,
    output logic              lane1,
    output logic              clk_copy,
    output logic [1:0]        pwr_state
);
    localparam int FRAME_W = DATA_W + 1 + RSV_W;

    logic cap_edge, cap_load, run_next, frame_valid;
    pwr_e run_state;

    pxser_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk_bit  (clk_bit),
        .rst_n    (shutdown_n),
        .pix_clk  (pix_clk),
        .cap_fall (cap_fall),
        .cap_edge (cap_edge)
    );

    pxser_power #(.IDLE_LIMIT(IDLE_LIMIT)) u_power (
        .clk_bit  (clk_bit),
        .rst_n    (shutdown_n),
        .cap_edge (cap_edge),
        .state_q  (run_state),
        .run_next (run_next),
        .cap_load (cap_load)
    );

    pxser_shift #(.DATA_W(DATA_W), .RSV_W(RSV_W)) u_shift (
        .clk_bit     (clk_bit),
        .rst_n       (shutdown_n),
        .run_next    (run_next),
        .cap_load    (cap_load),
        .dual_lane   (dual_lane),
        .pix_word    (pix_word),
        .lane0       (lane0),
        .lane1       (lane1),
        .frame_valid (frame_valid)
    );

    pxser_clkcopy #(.FRAME_W(FRAME_W)) u_clk (
        .clk_bit     (clk_bit),
        .rst_n       (shutdown_n),
        .cap_load    (cap_load),
        .dual_lane   (dual_lane),
        .frame_valid (frame_valid),
        .clk_copy    (clk_copy)
    );

    // Shutdown overrides the held state code.
    assign pwr_state = shutdown_n ? run_state : PWR_OFF;
endmodule

// File: rtl/pxser_chk.sv
`timescale 1ns/1ps
// Property checker for pxser_top, attached by bind.
module pxser_chk #(
    parameter int DATA_W = 27
) (
    input logic              clk_bit,
    input logic              shutdown_n,
    input logic [DATA_W-1:0] pix_word,
    input logic              lane0,
    input logic              lane1,
    input logic              clk_copy,
    input logic [1:0]        pwr_state,
    input logic              cap_load
);
    localparam logic [1:0] ST_STBY = 2'b01;
    localparam logic [1:0] ST_RUN  = 2'b10;

    // R6
    standby_quiet_chk: assert property (@(posedge clk_bit) disable iff (!shutdown_n)
        (pwr_state == ST_STBY) |-> (!lane0 && !lane1 && !clk_copy))
        else $error("standby with active outputs");

    // R7
    wake_silent_chk: assert property (@(posedge clk_bit) disable iff (!shutdown_n)
        (pwr_state == ST_RUN && $past(pwr_state) == ST_STBY) |-> (!lane0 && !lane1 && !clk_copy))
        else $error("frame sent on wake edge");

    // R4
    first_bit_chk: assert property (@(posedge clk_bit) disable iff (!shutdown_n)
        cap_load |=> (lane0 == $past(pix_word[0])))
        else $error("first serial bit is not word bit 0");

    // R5
    clk_start_chk: assert property (@(posedge clk_bit) disable iff (!shutdown_n)
        cap_load |=> clk_copy)
        else $error("clock copy low at frame start");

    // R10
    pwr_code_chk: assert property (@(posedge clk_bit) disable iff (!shutdown_n)
        pwr_state != 2'b11)
        else $error("illegal power code");
endmodule

bind pxser_top pxser_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_bit    (clk_bit),
    .shutdown_n (shutdown_n),
    .pix_word   (pix_word),
    .lane0      (lane0),
    .lane1      (lane1),
    .clk_copy   (clk_copy),
    .pwr_state  (pwr_state),
    .cap_load   (cap_load)
);

// File: tb/pxser_top_tb.sv
`timescale 1ns/1ps
module pxser_top_tb;
    localparam int LAT = 3;

    logic        clk_bit = 1'b0;
    logic        shutdown_n = 1'b0;
    logic        pix_clk = 1'b0;
    logic        cap_fall = 1'b0;
    logic        dual_lane = 1'b0;
    logic [26:0] pix_word = '0;
    logic        lane0, lane1, clk_copy;
    logic [1:0]  pwr_state;

    int  errs = 0;
    int  checks = 0;
    bit  done = 0;
    int  per = 30;
    bit  awake = 0;
    bit  prev_v = 0;
    logic [29:0] prev_f = '0;
    logic [29:0] g0 = '0, g1 = '0, gc = '0;

    // Vectors: {cap_fall, dual_lane, word}
    localparam logic [28:0] VEC [8] = '{
        {1'b0, 1'b0, 27'h0000000},
        {1'b0, 1'b0, 27'h7FFFFFF},
        {1'b0, 1'b0, 27'h5A5A5A5},
        {1'b0, 1'b1, 27'h1234567},
        {1'b0, 1'b1, 27'h7654321},
        {1'b1, 1'b1, 27'h0F0F0F0},
        {1'b1, 1'b1, 27'h3C3C3C3},
        {1'b1, 1'b0, 27'h2AAAAAA}
    };

    pxser_top u_dut (
        .clk_bit    (clk_bit),
        .shutdown_n (shutdown_n),
        .pix_clk    (pix_clk),
        .cap_fall   (cap_fall),
        .dual_lane  (dual_lane),
        .pix_word   (pix_word),
        .lane0      (lane0),
        .lane1      (lane1),
        .clk_copy   (clk_copy),
        .pwr_state  (pwr_state)
    );

    always #5 clk_bit = ~clk_bit;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [29:0] mkframe(input logic [26:0] d);
        return {2'b00, ~^d, d};
    endfunction

    // Compares the collected bits of the previous frame with the model.
    task automatic compare_prev();
        logic [29:0] e0, e1, ec, m;
        string t0;
        if (dual_lane) begin
            m  = 30'h7FFF;
            e0 = {15'b0, prev_f[14:0]};
            e1 = {15'b0, prev_f[29:15]};
            ec = 30'h00FF;
            t0 = "R3";
        end else begin
            m  = 30'h3FFFFFFF;
            e0 = prev_f;
            e1 = '0;
            ec = 30'h7FFF;
            t0 = cap_fall ? "R4" : "R1";
        end
        chk((g0 & m) == e0, t0, "lane0 frame", {2'b0, g0 & m}, {2'b0, e0});
        chk((g1 & m) == e1, dual_lane ? "R3" : "R2", "lane1 frame", {2'b0, g1 & m}, {2'b0, e1});
        chk((gc & m) == ec, "R5", "clock copy", {2'b0, gc & m}, {2'b0, ec});
        g0 = '0; g1 = '0; gc = '0;
    endtask

    // Runs len bit cycles; with cap set, one pixel period starting with a capture.
    task automatic step(input logic [26:0] d, input bit cap, input int len);
        bit   wake = cap && !awake;
        bit   cur  = cap && awake;
        bit   silent = 1;
        logic cap_l = cap_fall ? 1'b0 : 1'b1;
        for (int k = 0; k < len; k++) begin
            @(negedge clk_bit);
            if (k < LAT && prev_v) begin
                g0[per-LAT+k] = lane0;
                g1[per-LAT+k] = lane1;
                gc[per-LAT+k] = clk_copy;
                if (k == LAT-1) begin
                    compare_prev();
                    prev_v = 0;
                end
            end else if (k >= LAT && cur && (k - LAT) < per) begin
                g0[k-LAT] = lane0;
                g1[k-LAT] = lane1;
                gc[k-LAT] = clk_copy;
            end
            if (wake && k >= LAT && (lane0 || lane1 || clk_copy)) silent = 0;
            if (cap) begin
                if (k == 0) pix_word = d;
                pix_clk = (k < per/2) ? cap_l : ~cap_l;
            end else begin
                pix_clk = ~cap_l;
            end
        end
        if (wake) begin
            chk(silent, "R7", "outputs quiet on wake period", {31'b0, !silent}, 32'd0);
            chk(pwr_state == 2'b10, "R7", "active after wake", {30'b0, pwr_state}, 32'd2);
            awake = 1;
        end
        if (cur) begin
            prev_f = mkframe(d);
            prev_v = 1;
        end
        if (!cap && len >= 64) awake = 0;
    endtask

    // Sleeps, switches mode, then wakes with one capture edge.
    task automatic go_mode(input bit nd, input bit nf);
        step('0, 0, 100);
        chk(pwr_state == 2'b01, "R6", "standby after idle", {30'b0, pwr_state}, 32'd1);
        chk({lane0, lane1, clk_copy} == 3'b000, "R6", "quiet in standby",
            {29'b0, lane0, lane1, clk_copy}, 32'd0);
        dual_lane = nd;
        cap_fall  = nf;
        per       = nd ? 15 : 30;
        pix_clk   = nf;
        step('0, 0, 10);
        step('0, 1, per);
    endtask

    initial begin
        repeat (150000) @(posedge clk_bit);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        // Reset / shutdown state
        repeat (4) @(negedge clk_bit);
        chk(pwr_state == 2'b00, "R8", "shutdown code", {30'b0, pwr_state}, 32'd0);
        chk({lane0, lane1, clk_copy} == 3'b000, "R8", "outputs low in shutdown",
            {29'b0, lane0, lane1, clk_copy}, 32'd0);
        shutdown_n = 1'b1;
        repeat (2) @(negedge clk_bit);
        chk(pwr_state == 2'b01, "R6", "standby after release", {30'b0, pwr_state}, 32'd1);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            if (i == 0 || VEC[i][28] != cap_fall || VEC[i][27] != dual_lane)
                go_mode(VEC[i][27], VEC[i][28]);
            step(VEC[i][26:0], 1, per);
        end

        // R9: short gap keeps the block active
        step(27'h1555555, 1, per);
        step('0, 0, 20);
        chk(pwr_state == 2'b10, "R9", "active across short gap", {30'b0, pwr_state}, 32'd2);
        step(27'h0000001, 1, per);
        step(27'h4000003, 1, per);

        // R8: shutdown in the middle of a frame
        @(negedge clk_bit);
        shutdown_n = 1'b0;
        prev_v = 0;
        g0 = '0; g1 = '0; gc = '0;
        @(negedge clk_bit);
        chk({lane0, lane1, clk_copy} == 3'b000, "R8", "frame dropped on shutdown",
            {29'b0, lane0, lane1, clk_copy}, 32'd0);
        chk(pwr_state == 2'b00, "R8", "shutdown code mid-run", {30'b0, pwr_state}, 32'd0);
        repeat (3) @(negedge clk_bit);
        shutdown_n = 1'b1;
        awake = 0;
        repeat (2) @(negedge clk_bit);
        chk(pwr_state == 2'b01, "R8", "standby after shutdown", {30'b0, pwr_state}, 32'd1);

        // Recovery in dual-lane, rising-edge mode
        go_mode(1'b1, 1'b0);
        step(27'h6DB6DB6, 1, per);
        step(27'h1111111, 1, per);
        step('0, 0, 100);
        chk(pwr_state != 2'b11, "R10", "legal power code", {30'b0, pwr_state}, 32'd1);
        chk(pwr_state == 2'b01, "R6", "standby at end", {30'b0, pwr_state}, 32'd1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule